// File: doc/BRIEF.md
# Ghost-Cancelling Best-Two Track Selector

This block takes one bunch crossing's worth of muon track candidates from six neighbouring track-finder units. Each unit supplies two slots, so there are twelve slots in all, each a 31-bit track word with its own valid bit. Neighbouring finders often rebuild the same muon from the same detector segments. The first pipeline stage finds such duplicate pairs by comparing their segment addresses and drops the weaker copy of each pair.

The second stage ranks every surviving candidate against every other one in parallel. It then routes the best and second-best tracks to two registered output slots. A new set of candidates can be presented on every clock cycle, and each set appears at the outputs exactly two clock edges later.

Track word layout, from bit 30 down:

| Bits | Field |
|------|-------|
| 30:28 | quality |
| 27:23 | transverse momentum |
| 22:17 | azimuth |
| 16:13 | pseudorapidity |
| 12 | charge |
| 11:0 | segment address: four 3-bit station fields, field k at bits 3k+2:3k |

Top module: `ghost_top2_sorter`

## Requirements
- R1: A candidate set sampled at one rising edge appears on the outputs after the second rising edge. A different set may be presented on every cycle.
- R2: The rank is word bits 30:23, compared as an unsigned number, so quality (30:28) dominates momentum (27:23). `best_*` carries the highest-ranked surviving track and `next_*` carries the second highest.
- R3: When ranks are equal in the sorting stage, the lower slot index is ordered first.
- R4: Slots 2u and 2u+1 belong to finder unit u. Duplicate search runs only between units u and u+1 (u = 0..4). There is no wrap-around, and no comparison is made within one unit.
- R5: Two tracks match when, for some field index k, their 3-bit segment fields k are equal and nonzero. A zero field is null and never matches.
- R6: Of a matching pair, the lower-ranked track is invalidated. On equal rank, the track from the higher unit index is invalidated.
- R7: Cancellation is judged on the input valid bits. A track that is itself cancelled still cancels a weaker match in the next unit.
- R8: When fewer than two tracks survive, each missing output has its valid flag low and its word all zeros.
- R9: While reset is low, both outputs are invalid with zero words.
- R10: `next_vld` high implies `best_vld` high, with the rank of `best_trk` not below the rank of `next_trk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_trk | input | 372 | Twelve track words, slot s at bits 31s+30:31s |
| in_vld | input | 12 | Valid bit per slot |
| best_trk | output | 31 | Highest-ranked surviving track |
| best_vld | output | 1 | best_trk holds a track |
| next_trk | output | 31 | Second-ranked surviving track |
| next_vld | output | 1 | next_trk holds a track |

## Verification
The vector table places two or three tracks in chosen slots. This isolates each rule on its own:
- an adjacent-unit shared segment (cancelled) against the same addresses two units apart (kept);
- shared null fields (kept) against a shared nonzero field (cancelled);
- a pair inside one unit (kept);
- equal-rank duplicates (the higher unit loses) against a winner in the higher unit;
- a three-unit chain, which tells raw-valid judgement apart from judgement on survivors.

Full loads with ascending and descending ranks check the all-pairs ordering. Back-to-back sets check the two-stage pipeline. Equal-rank and quality-versus-momentum pairs pin down the comparison order.

// File: rtl/gts_pkg.sv
package gts_pkg;
  localparam int QUAL_W = 3;
  localparam int PT_W   = 5;
  localparam int RANK_W = QUAL_W + PT_W;
  localparam int PHI_W  = 6;
  localparam int ETA_W  = 4;
  localparam int FLD_W  = 3;
  localparam int N_FLD  = 4;
  localparam int ADDR_W = FLD_W * N_FLD;
  localparam int TRK_W  = RANK_W + PHI_W + ETA_W + 1 + ADDR_W;

  typedef logic [TRK_W-1:0]  trk_t;
  typedef logic [RANK_W-1:0] rank_t;

  function automatic rank_t rank_of(trk_t t);
    return t[TRK_W-1 -: RANK_W];
  endfunction

  // any station field equal and non-null
  function automatic logic seg_match(trk_t a, trk_t b);
    logic m;
    m = 1'b0;
    for (int k = 0; k < N_FLD; k++) begin
      if (a[k*FLD_W +: FLD_W] != '0 && a[k*FLD_W +: FLD_W] == b[k*FLD_W +: FLD_W])
        m = 1'b1;
    end
    return m;
  endfunction

  // a beats b: higher rank, or equal rank and lower position
  function automatic logic outranks(rank_t ra, int pa, rank_t rb, int pb);
    return (ra > rb) || (ra == rb && pa < pb);
  endfunction
endpackage

// File: rtl/gts_ghost_kill.sv
module gts_ghost_kill
  import gts_pkg::*;
#(
  parameter int N_UNIT   = 6,
  parameter int PER_UNIT = 2,
  localparam int N_SLOT  = N_UNIT * PER_UNIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trk_t              trk   [N_SLOT],
  input  logic [N_SLOT-1:0] vld,
  output logic [N_SLOT-1:0] kill,
  output trk_t              s1_trk [N_SLOT],
  output logic [N_SLOT-1:0] s1_vld
);
  logic [N_SLOT-1:0] beaten [N_SLOT];

  for (genvar i = 0; i < N_SLOT; i++) begin : g_row
    for (genvar j = 0; j < N_SLOT; j++) begin : g_col
      localparam int UI = i / PER_UNIT;
      localparam int UJ = j / PER_UNIT;
      if (UI == UJ + 1 || UJ == UI + 1) begin : g_adj
        assign beaten[i][j] = vld[i] & vld[j] & seg_match(trk[i], trk[j])
                              & outranks(rank_of(trk[j]), UJ, rank_of(trk[i]), UI);
      end else begin : g_far
        assign beaten[i][j] = 1'b0;
      end
    end
    assign kill[i] = |beaten[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= '0;
      for (int i = 0; i < N_SLOT; i++) s1_trk[i] <= '0;
    end else begin
      s1_vld <= vld & ~kill;
      for (int i = 0; i < N_SLOT; i++) s1_trk[i] <= trk[i];
    end
  end
endmodule

// File: rtl/gts_rank_count.sv
module gts_rank_count
  import gts_pkg::*;
#(
  parameter int N_SLOT = 12,
  localparam int CNT_W = $clog2(N_SLOT + 1)
) (
  input  trk_t             trk [N_SLOT],
  input  logic [N_SLOT-1:0] vld,
  output logic [CNT_W-1:0] cnt [N_SLOT]
);
  always_comb begin
    for (int i = 0; i < N_SLOT; i++) begin
      cnt[i] = '0;
      for (int j = 0; j < N_SLOT; j++) begin
        if (j != i && vld[j] && outranks(rank_of(trk[j]), j, rank_of(trk[i]), i))
          cnt[i] = cnt[i] + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/gts_out_mux.sv
module gts_out_mux
  import gts_pkg::*;
#(
  parameter int N_SLOT = 12,
  localparam int CNT_W = $clog2(N_SLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trk_t             trk [N_SLOT],
  input  logic [N_SLOT-1:0] vld,
  input  logic [CNT_W-1:0] cnt [N_SLOT],
  output trk_t             best_trk,
  output logic             best_vld,
  output trk_t             next_trk,
  output logic             next_vld
);
  trk_t pick0, pick1;
  logic has0, has1;

  always_comb begin
    pick0 = '0;
    pick1 = '0;
    has0  = 1'b0;
    has1  = 1'b0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (vld[i] && cnt[i] == CNT_W'(0)) begin
        pick0 = pick0 | trk[i];
        has0  = 1'b1;
      end
      if (vld[i] && cnt[i] == CNT_W'(1)) begin
        pick1 = pick1 | trk[i];
        has1  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_trk <= '0;
      best_vld <= 1'b0;
      next_trk <= '0;
      next_vld <= 1'b0;
    end else begin
      best_trk <= pick0;
      best_vld <= has0;
      next_trk <= pick1;
      next_vld <= has1;
    end
  end
endmodule

// File: rtl/ghost_top2_sorter.sv
module ghost_top2_sorter
  import gts_pkg::*;
#(
  parameter int N_UNIT   = 6,
  parameter int PER_UNIT = 2,
  localparam int N_SLOT  = N_UNIT * PER_UNIT,
  localparam int CNT_W   = $clog2(N_SLOT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SLOT*TRK_W-1:0] in_trk,
  input  logic [N_SLOT-1:0]       in_vld,
  output logic [TRK_W-1:0]        best_trk,
  output logic                    best_vld,
  output logic [TRK_W-1:0]        next_trk,
  output logic                    next_vld
);
  trk_t              in_arr [N_SLOT];
  trk_t              s1_trk [N_SLOT];
  logic [N_SLOT-1:0] s1_vld;
  logic [N_SLOT-1:0] kill_w;
  logic [CNT_W-1:0]  cnt_w  [N_SLOT];

  for (genvar s = 0; s < N_SLOT; s++) begin : g_unpack
    assign in_arr[s] = in_trk[s*TRK_W +: TRK_W];
  end

  gts_ghost_kill #(.N_UNIT(N_UNIT), .PER_UNIT(PER_UNIT)) u_ghost (
    .clk(clk), .rst_n(rst_n), .trk(in_arr), .vld(in_vld),
    .kill(kill_w), .s1_trk(s1_trk), .s1_vld(s1_vld)
  );

  gts_rank_count #(.N_SLOT(N_SLOT)) u_rank (
    .trk(s1_trk), .vld(s1_vld), .cnt(cnt_w)
  );

  gts_out_mux #(.N_SLOT(N_SLOT)) u_mux (
    .clk(clk), .rst_n(rst_n), .trk(s1_trk), .vld(s1_vld), .cnt(cnt_w),
    .best_trk(best_trk), .best_vld(best_vld),
    .next_trk(next_trk), .next_vld(next_vld)
  );
endmodule

// File: rtl/gts_chk.sv
module gts_chk
  import gts_pkg::*;
#(
  parameter int N_SLOT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SLOT-1:0] in_vld,
  input logic [N_SLOT-1:0] kill,
  input logic [N_SLOT-1:0] s1_vld,
  input logic [TRK_W-1:0]  best_trk,
  input logic              best_vld,
  input logic [TRK_W-1:0]  next_trk,
  input logic              next_vld
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!best_vld && !next_vld && best_trk == '0 && next_trk == '0));

  // R10
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_vld |-> (best_vld && rank_of(best_trk) >= rank_of(next_trk)));

  // R6
  best_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_vld) |-> (|(in_vld & ~kill)));

  // R6
  survivor_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> ((s1_vld & ~$past(in_vld)) == '0));

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(|in_vld, 2)) |-> best_vld);
endmodule

bind ghost_top2_sorter gts_chk #(.N_SLOT(N_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .kill(kill_w), .s1_vld(s1_vld),
  .best_trk(best_trk), .best_vld(best_vld), .next_trk(next_trk), .next_vld(next_vld)
);

// File: tb/sim_ghost_top2_sorter.sv
module sim_ghost_top2_sorter;
  localparam int NS = 12;
  localparam int W  = 31;

  typedef struct packed {
    logic       v;
    logic [3:0] s;
    logic [7:0] r;
    logic [11:0] a;
  } cand_t;

  typedef struct packed {
    cand_t      a;
    cand_t      b;
    cand_t      c;
    logic [3:0] e1;
    logic [3:0] e2;
  } vec_t;

  localparam cand_t NO = '{1'b0, 4'd0, 8'h00, 12'o0000};
  localparam logic [3:0] NONE = 4'd15;

  localparam vec_t TBL [12] = '{
    '{'{1'b1, 4'd0, 8'h40, 12'o1111}, '{1'b1, 4'd5, 8'h90, 12'o2222}, '{1'b1, 4'd11, 8'h60, 12'o3333}, 4'd5, 4'd11},
    '{'{1'b1, 4'd1, 8'h80, 12'o1200}, '{1'b1, 4'd2, 8'h70, 12'o1500}, '{1'b1, 4'd9, 8'h20, 12'o7777}, 4'd1, 4'd9},
    '{'{1'b1, 4'd1, 8'h80, 12'o1200}, '{1'b1, 4'd4, 8'h70, 12'o1500}, NO, 4'd1, 4'd4},
    '{'{1'b1, 4'd2, 8'h50, 12'o0123}, '{1'b1, 4'd4, 8'h60, 12'o0456}, NO, 4'd4, 4'd2},
    '{'{1'b1, 4'd6, 8'h55, 12'o0070}, '{1'b1, 4'd8, 8'h55, 12'o0070}, '{1'b1, 4'd0, 8'h10, 12'o0000}, 4'd6, 4'd0},
    '{'{1'b1, 4'd10, 8'h30, 12'o4444}, '{1'b1, 4'd11, 8'h31, 12'o4444}, NO, 4'd11, 4'd10},
    '{'{1'b1, 4'd3, 8'h77, 12'o1111}, '{1'b1, 4'd7, 8'h77, 12'o2222}, '{1'b1, 4'd2, 8'h10, 12'o3333}, 4'd3, 4'd7},
    '{'{1'b1, 4'd0, 8'h5F, 12'o1111}, '{1'b1, 4'd1, 8'h60, 12'o2222}, NO, 4'd1, 4'd0},
    '{'{1'b1, 4'd4, 8'h01, 12'o0000}, NO, NO, 4'd4, NONE},
    '{'{1'b1, 4'd3, 8'h20, 12'o0001}, '{1'b1, 4'd4, 8'hA0, 12'o0001}, '{1'b1, 4'd7, 8'h30, 12'o0002}, 4'd4, 4'd7},
    '{NO, NO, NO, NONE, NONE},
    '{'{1'b1, 4'd0, 8'h90, 12'o1000}, '{1'b1, 4'd2, 8'h80, 12'o1200}, '{1'b1, 4'd4, 8'h70, 12'o0200}, 4'd0, NONE}
  };

  localparam string TAGS [12] = '{
    "R2 plain sort", "R4 adjacent ghost", "R4 distant units kept",
    "R5 null fields", "R6 equal-rank ghost", "R4 same unit kept",
    "R3 sort tie", "R2 quality over pt", "R8 single track",
    "R6 low-index loser", "R8 empty set", "R7 ghost chain"
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS*W-1:0] in_trk = '0;
  logic [NS-1:0]   in_vld = '0;
  logic [W-1:0]    best_trk, next_trk;
  logic            best_vld, next_vld;
  int              checks = 0;
  int              errors = 0;

  always #4 clk = ~clk;

  ghost_top2_sorter u0 (
    .clk(clk), .rst_n(rst_n), .in_trk(in_trk), .in_vld(in_vld),
    .best_trk(best_trk), .best_vld(best_vld), .next_trk(next_trk), .next_vld(next_vld)
  );

  function automatic logic [W-1:0] mk(int slot, logic [7:0] r, logic [11:0] a);
    return {r, 6'(slot), 4'd0, 1'b0, a};
  endfunction

  function automatic logic [W-1:0] exp_word(vec_t v, logic [3:0] e);
    if (e == NONE) return '0;
    if (v.a.v && v.a.s == e) return mk(int'(e), v.a.r, v.a.a);
    if (v.b.v && v.b.s == e) return mk(int'(e), v.b.r, v.b.a);
    if (v.c.v && v.c.s == e) return mk(int'(e), v.c.r, v.c.a);
    return '0;
  endfunction

  task automatic chk(string req, logic gv, logic [W-1:0] gw, logic ev, logic [W-1:0] ew);
    checks++;
    if (gv !== ev || gw !== ew) begin
      errors++;
      $display("FAIL %s: got vld=%0b trk=%h, expected vld=%0b trk=%h", req, gv, gw, ev, ew);
    end
  endtask

  task automatic put(cand_t c);
    if (c.v) begin
      in_trk[int'(c.s)*W +: W] = mk(int'(c.s), c.r, c.a);
      in_vld[c.s] = 1'b1;
    end
  endtask

  task automatic drive(vec_t v);
    in_trk = '0;
    in_vld = '0;
    put(v.a);
    put(v.b);
    put(v.c);
  endtask

  task automatic check_vec(string tag, vec_t v);
    chk({tag, " best"}, best_vld, best_trk, v.e1 != NONE, exp_word(v, v.e1));
    chk({tag, " next"}, next_vld, next_trk, v.e2 != NONE, exp_word(v, v.e2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // reset state, R9
    repeat (3) @(negedge clk);
    chk("R9 reset best", best_vld, best_trk, 1'b0, '0);
    chk("R9 reset next", next_vld, next_trk, 1'b0, '0);
    rst_n = 1'b1;

    // vector table walk
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      drive(TBL[k]);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check_vec(TAGS[k], TBL[k]);
    end

    // R2: full load, ascending ranks, null addresses
    @(negedge clk);
    in_vld = '1;
    for (int s = 0; s < NS; s++) in_trk[s*W +: W] = mk(s, 8'(8'h10 + 3*s), 12'o0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R2 full ascending best", best_vld, best_trk, 1'b1, mk(11, 8'h31, 12'o0));
    chk("R2 full ascending next", next_vld, next_trk, 1'b1, mk(10, 8'h2E, 12'o0));

    // R2: full load, descending ranks
    for (int s = 0; s < NS; s++) in_trk[s*W +: W] = mk(s, 8'(8'hF0 - 3*s), 12'o0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R2 full descending best", best_vld, best_trk, 1'b1, mk(0, 8'hF0, 12'o0));
    chk("R2 full descending next", next_vld, next_trk, 1'b1, mk(1, 8'hED, 12'o0));

    // R1: back-to-back sets, one per cycle
    drive(TBL[0]);
    @(negedge clk);
    drive(TBL[6]);
    @(negedge clk);
    drive(TBL[10]);
    check_vec("R1 pipelined first", TBL[0]);
    @(negedge clk);
    check_vec("R1 pipelined second", TBL[6]);
    @(negedge clk);
    check_vec("R1 pipelined third", TBL[10]);

    // R9: reset during activity
    drive(TBL[1]);
    repeat (2) @(negedge clk);
    check_vec("R1 before reset", TBL[1]);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid reset best", best_vld, best_trk, 1'b0, '0);
    chk("R9 mid reset next", next_vld, next_trk, 1'b0, '0);
    rst_n = 1'b1;
    in_vld = '0;
    repeat (3) @(negedge clk);
    // R10: outputs of a fresh set stay ordered
    drive(TBL[3]);
    repeat (2) @(negedge clk);
    check_vec("R10 order after reset", TBL[3]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule